// File: doc/BRIEF.md
# Streaming Write Burst Generator

This block turns an outgoing data stream of unknown total length into bus write bursts. A transfer begins with a start address. Data then arrives as 64-bit beats, and the final beat carries an end marker. For each burst the block issues a request that gives the address and a declared byte count. It then forwards the beats in order and flags the beat that closes the burst.

A mode bit is sampled when a transfer starts, and it selects one of two behaviours:

- **Compliant mode.** No burst exceeds 128 bytes. Every burst closes on a 128-byte address boundary.
- **Long-burst mode.** Each burst declares every byte left up to the next 4 KB boundary before the real length is known. When the target asks for a disconnect, the burst may close early, but only on a 128-byte boundary. The remaining data always continues in a fresh burst at the exact next byte address; a closed burst is never resumed.

Beats are 8 bytes, and addresses count in bytes. The low three bits of the start address are treated as zero.

Top module: `swb_burst_gen`

## Requirements
- R1: In compliant mode each request declares 128 minus (address mod 128) bytes. The burst closes on the beat after which the address is a multiple of 128, or earlier on the end marker.
- R2: In long-burst mode each request declares 4096 minus (address mod 4096) bytes.
- R3: No burst crosses a 4096-byte address boundary. When the next address is a multiple of 4096, the burst closes, and any further data gets a new request at that address.
- R4: In long-burst mode, a disconnect seen during the data phase closes the burst on the first later-or-same beat after which the address is a multiple of 128. The next request starts at the following byte address with a recomputed count.
- R5: Gaps in the input stream never close a burst. The burst stays open, with no new request, until a boundary or the end marker.
- R6: The beat carrying the end marker always closes the burst, even off a boundary. The block then returns to idle and issues no further request.
- R7: The bytes carried by a burst never exceed its declared count.
- R8: The start address and mode bit are taken only when the block is idle. A start pulse or mode change during a transfer has no effect on the bursts.
- R9: Beats are forwarded unchanged and in order, one per accepted input. `in_ready` is high only in the data phase of a burst, and a request is raised only once a first beat is waiting.
- R10: After reset, no request is raised, no beat is forwarded and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Starts a transfer when idle |
| start_addr | input | 32 | First byte address of the transfer |
| long_mode | input | 1 | 1 = long-burst mode, 0 = compliant mode |
| in_valid | input | 1 | Input beat present |
| in_data | input | 64 | Input beat payload |
| in_last | input | 1 | Marks the final beat of the transfer |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| tgt_disc | input | 1 | Target asks to disconnect the current burst |
| req_valid | output | 1 | Burst request strobe |
| req_addr | output | 32 | Burst start byte address |
| req_bytes | output | 13 | Declared byte count of the burst |
| beat_valid | output | 1 | Output beat strobe |
| beat_data | output | 64 | Output beat payload |
| beat_end | output | 1 | This beat closes the current burst |

## Verification
A boundary close and the end marker can fall on the same beat. The bench provokes this with a disconnect on the very last beat of a long-burst transfer, where that beat also completes a 128-byte block. The bench then expects exactly one closing beat and a single request. It also checks that a following transfer still starts normally, which proves the block returned to idle rather than waiting for more data.

// File: rtl/swb_pkg.sv
package swb_pkg;

    localparam int BEAT_BYTES = 8;
    localparam int DATA_W     = BEAT_BYTES * 8;
    localparam int BLK_BYTES  = 128;
    localparam int PAGE_BYTES = 4096;
    localparam int BLK_LSB    = $clog2(BLK_BYTES);
    localparam int PAGE_LSB   = $clog2(PAGE_BYTES);
    localparam int SPAN_W     = PAGE_LSB + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA
    } swb_state_e;

    // reasons a burst may close on the current beat
    typedef struct packed {
        logic last;
        logic page;
        logic blk;
        logic disc;
    } swb_end_t;

    // bytes a new burst may declare from a given offset inside its page
    function automatic logic [SPAN_W-1:0] span_bytes(input logic [PAGE_LSB-1:0] off,
                                                     input logic long_m);
        logic [SPAN_W-1:0] page_left;
        logic [SPAN_W-1:0] blk_left;
        page_left = SPAN_W'(PAGE_BYTES) - SPAN_W'(off);
        blk_left  = SPAN_W'(BLK_BYTES) - SPAN_W'(off[BLK_LSB-1:0]);
        return long_m ? page_left : blk_left;
    endfunction

endpackage

// File: rtl/swb_span_calc.sv
module swb_span_calc
    import swb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              long_m,
    output logic [SPAN_W-1:0] decl_bytes,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              nxt_blk_edge,
    output logic              nxt_page_edge
);
    always_comb begin
        decl_bytes    = span_bytes(cur_addr[PAGE_LSB-1:0], long_m);
        nxt_addr      = cur_addr + ADDR_W'(BEAT_BYTES);
        nxt_blk_edge  = (nxt_addr[BLK_LSB-1:0] == '0);
        nxt_page_edge = (nxt_addr[PAGE_LSB-1:0] == '0);
    end
endmodule

// File: rtl/swb_disc_track.sv
module swb_disc_track (
    input  logic clk,
    input  logic rst,
    input  logic data_phase,
    input  logic tgt_disc,
    input  logic burst_close,
    output logic disc_hit
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (burst_close)
            pend_q <= 1'b0;
        else if (data_phase && tgt_disc)
            pend_q <= 1'b1;
    end

    assign disc_hit = data_phase && (pend_q || tgt_disc);

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        burst_close |=> !pend_q);
endmodule

// File: rtl/swb_seq.sv
module swb_seq
    import swb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              long_mode,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [SPAN_W-1:0] decl_bytes,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic              nxt_blk_edge,
    input  logic              nxt_page_edge,
    input  logic              disc_hit,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mode_q,
    output logic              data_phase,
    output logic              req_valid,
    output logic              in_ready,
    output logic              beat_valid,
    output logic              beat_end
);
    swb_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SPAN_W-1:0] decl_q;
    logic [SPAN_W-1:0] sent_q;
    swb_end_t          ends;

    always_comb begin
        data_phase = (state_q == ST_DATA);
        req_valid  = (state_q == ST_REQ) && in_valid;
        in_ready   = data_phase;
        beat_valid = data_phase && in_valid;
        ends.last  = in_last;
        ends.page  = nxt_page_edge;
        ends.blk   = nxt_blk_edge && !mode_q;
        ends.disc  = nxt_blk_edge && mode_q && disc_hit;
        beat_end   = beat_valid && (|ends);
        cur_addr   = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            mode_q  <= 1'b0;
            decl_q  <= '0;
            sent_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_valid) begin
                    addr_q  <= start_addr & ~ADDR_W'(BEAT_BYTES - 1);
                    mode_q  <= long_mode;
                    state_q <= ST_REQ;
                end
                ST_REQ: if (in_valid) begin
                    decl_q  <= decl_bytes;
                    sent_q  <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: if (beat_valid) begin
                    addr_q <= nxt_addr;
                    sent_q <= sent_q + SPAN_W'(BEAT_BYTES);
                    if (beat_end)
                        state_q <= in_last ? ST_IDLE : ST_REQ;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7
    decl_cover_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> ({1'b0, sent_q} + (SPAN_W+1)'(BEAT_BYTES)) <= {1'b0, decl_q});
    // R1
    cmp_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mode_q) |-> (decl_bytes <= SPAN_W'(BLK_BYTES)) && (decl_bytes != '0));
    // R2
    long_span_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode_q) |-> ({1'b0, decl_bytes} + (SPAN_W+1)'(addr_q[PAGE_LSB-1:0]))
                                  == (SPAN_W+1)'(PAGE_BYTES));
    // R6
    last_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_end && in_last) |=> (state_q == ST_IDLE));
    // R3
    reopen_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_end && !in_last) |=> !in_ready);
    // R9
    req_no_beat_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !beat_valid);
endmodule

// File: rtl/swb_burst_gen.sv
module swb_burst_gen
    import swb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              long_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              tgt_disc,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SPAN_W-1:0] req_bytes,
    output logic              beat_valid,
    output logic [DATA_W-1:0] beat_data,
    output logic              beat_end
);
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic [SPAN_W-1:0] decl_bytes;
    logic              nxt_blk_edge;
    logic              nxt_page_edge;
    logic              mode_q;
    logic              data_phase;
    logic              disc_hit;

    swb_span_calc #(.ADDR_W(ADDR_W)) span_i (
        .cur_addr      (cur_addr),
        .long_m        (mode_q),
        .decl_bytes    (decl_bytes),
        .nxt_addr      (nxt_addr),
        .nxt_blk_edge  (nxt_blk_edge),
        .nxt_page_edge (nxt_page_edge)
    );

    swb_disc_track disc_i (
        .clk         (clk),
        .rst         (rst),
        .data_phase  (data_phase),
        .tgt_disc    (tgt_disc),
        .burst_close (beat_end),
        .disc_hit    (disc_hit)
    );

    swb_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk           (clk),
        .rst           (rst),
        .start_valid   (start_valid),
        .start_addr    (start_addr),
        .long_mode     (long_mode),
        .in_valid      (in_valid),
        .in_last       (in_last),
        .decl_bytes    (decl_bytes),
        .nxt_addr      (nxt_addr),
        .nxt_blk_edge  (nxt_blk_edge),
        .nxt_page_edge (nxt_page_edge),
        .disc_hit      (disc_hit),
        .cur_addr      (cur_addr),
        .mode_q        (mode_q),
        .data_phase    (data_phase),
        .req_valid     (req_valid),
        .in_ready      (in_ready),
        .beat_valid    (beat_valid),
        .beat_end      (beat_end)
    );

    assign req_addr  = cur_addr;
    assign req_bytes = decl_bytes;
    assign beat_data = in_data;
endmodule

// File: tb/swb_burst_gen_tb.sv
module swb_burst_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXREC = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic [31:0] start_addr = '0;
    logic        long_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        tgt_disc = 1'b0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [12:0] req_bytes;
    logic        beat_valid;
    logic [63:0] beat_data;
    logic        beat_end;

    int n_chk = 0;
    int n_fail = 0;
    int nreq = 0;
    int nbt = 0;
    logic [31:0] rq_addr  [MAXREC];
    logic [12:0] rq_bytes [MAXREC];
    logic [63:0] bt_data  [MAXREC];
    logic        bt_end   [MAXREC];

    always #(CLK_PERIOD/2) clk = ~clk;

    swb_burst_gen dut_i (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_addr(start_addr),
        .long_mode(long_mode), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .tgt_disc(tgt_disc), .req_valid(req_valid), .req_addr(req_addr),
        .req_bytes(req_bytes), .beat_valid(beat_valid), .beat_data(beat_data), .beat_end(beat_end)
    );

    always @(negedge clk) begin
        if (!rst && req_valid && nreq < MAXREC) begin
            rq_addr[nreq]  = req_addr;
            rq_bytes[nreq] = req_bytes;
            nreq++;
        end
        if (!rst && beat_valid && nbt < MAXREC) begin
            bt_data[nbt] = beat_data;
            bt_end[nbt]  = beat_end;
            nbt++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic begin_xfer(input logic [31:0] a, input logic m);
        nreq = 0;
        nbt = 0;
        @(posedge clk); #1;
        start_valid = 1'b1; start_addr = a; long_mode = m;
        @(posedge clk); #1;
        start_valid = 1'b0;
    endtask

    function automatic logic [63:0] pat(input int tag, input int i);
        return {16'hC0DE, 16'(tag), 32'(i)};
    endfunction

    task automatic send(input int n, input int tag, input int stall,
                        input int disc_beat, input int poke_beat);
        for (int i = 0; i < n; i++) begin
            logic acc;
            in_valid = 1'b1; in_data = pat(tag, i); in_last = (i == n - 1);
            tgt_disc = (i == disc_beat);
            if (i == poke_beat) begin
                start_valid = 1'b1; start_addr = 32'h9000; long_mode = ~long_mode;
            end
            do begin
                @(negedge clk); acc = in_ready;
                @(posedge clk); #1; start_valid = 1'b0;
            end while (!acc);
            in_valid = 1'b0; in_last = 1'b0; tgt_disc = 1'b0;
            if (stall > 0 && (i % 5) == 4)
                repeat (stall) begin @(posedge clk); #1; end
        end
        repeat (4) begin @(posedge clk); #1; end
    endtask

    task automatic check_data(input string req, input int n, input int tag);
        int bad = -1;
        chk(nbt == n, req, nbt, n);
        for (int i = 0; i < n && i < MAXREC; i++)
            if (bad < 0 && bt_data[i] !== pat(tag, i)) bad = i;
        chk(bad < 0, req, (bad < 0) ? 0 : bt_data[bad], (bad < 0) ? 0 : pat(tag, bad));
    endtask

    task automatic check_req(input string req, input int k, input logic [31:0] a, input int b);
        chk(rq_addr[k] === a, req, rq_addr[k], a);
        chk(rq_bytes[k] === 13'(b), req, rq_bytes[k], b);
    endtask

    task automatic check_ends(input string req, input int e0, input int e1, input int e2);
        int cnt = 0;
        int want = 0;
        for (int i = 0; i < nbt && i < MAXREC; i++) if (bt_end[i]) cnt++;
        if (e0 >= 0) begin want++; chk(bt_end[e0] === 1'b1, req, bt_end[e0], 1); end
        if (e1 >= 0) begin want++; chk(bt_end[e1] === 1'b1, req, bt_end[e1], 1); end
        if (e2 >= 0) begin want++; chk(bt_end[e2] === 1'b1, req, bt_end[e2], 1); end
        chk(cnt == want, req, cnt, want);
    endtask

    // R10, R9: idle outputs, data before start is not taken
    task automatic t_reset;
        chk(req_valid === 1'b0 && beat_valid === 1'b0 && in_ready === 1'b0, "R10",
            {req_valid, beat_valid, in_ready}, 0);
        nreq = 0; nbt = 0;
        in_valid = 1'b1;
        repeat (3) begin @(posedge clk); #1; end
        chk(in_ready === 1'b0 && nreq == 0 && nbt == 0, "R9 no accept while idle",
            nreq + nbt, 0);
        in_valid = 1'b0;
    endtask

    // R1: compliant aligned
    task automatic t_cmp_aligned;
        begin_xfer(32'h1000, 1'b0);
        send(40, 1, 0, -1, -1);
        chk(nreq == 3, "R1 req count", nreq, 3);
        check_req("R1", 0, 32'h1000, 128);
        check_req("R1", 1, 32'h1080, 128);
        check_req("R1", 2, 32'h1100, 128);
        check_ends("R1 ends", 15, 31, 39);
        check_data("R9 data", 40, 1);
    endtask

    // R1, R6, R7: compliant unaligned start, short tail
    task automatic t_cmp_unaligned;
        begin_xfer(32'h2040, 1'b0);
        send(10, 2, 0, -1, -1);
        chk(nreq == 2, "R1 req count", nreq, 2);
        check_req("R1", 0, 32'h2040, 64);
        check_req("R7", 1, 32'h2080, 128);
        check_ends("R6 ends", 7, 9, -1);
        check_data("R9 data", 10, 2);
    endtask

    // R2, R5, R8: long burst with gaps, start/mode poked mid-transfer
    task automatic t_long_stall;
        begin_xfer(32'h3000, 1'b1);
        send(40, 3, 3, -1, 20);
        chk(nreq == 1, "R5 one req despite gaps", nreq, 1);
        check_req("R2", 0, 32'h3000, 4096);
        check_ends("R8 ends", 39, -1, -1);
        check_data("R8 data", 40, 3);
    endtask

    // R3: page edge split in long mode
    task automatic t_long_page;
        begin_xfer(32'h4F80, 1'b1);
        send(20, 4, 0, -1, -1);
        chk(nreq == 2, "R3 req count", nreq, 2);
        check_req("R3", 0, 32'h4F80, 128);
        check_req("R3", 1, 32'h5000, 4096);
        check_ends("R3 ends", 15, 19, -1);
        check_data("R3 data", 20, 4);
    endtask

    // R4: disconnect mid-block, close at next 128-byte edge
    task automatic t_long_disc;
        begin_xfer(32'h6000, 1'b1);
        send(40, 5, 0, 5, -1);
        chk(nreq == 2, "R4 req count", nreq, 2);
        check_req("R4", 0, 32'h6000, 4096);
        check_req("R4", 1, 32'h6080, 3968);
        check_ends("R4 ends", 15, 39, -1);
        check_data("R4 data", 40, 5);
    endtask

    // R4 with R6 on the same beat
    task automatic t_disc_last;
        begin_xfer(32'h7000, 1'b1);
        send(16, 6, 0, 15, -1);
        chk(nreq == 1, "R6 single req", nreq, 1);
        check_req("R6", 0, 32'h7000, 4096);
        check_ends("R6 ends", 15, -1, -1);
        check_data("R6 data", 16, 6);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_cmp_aligned();
        t_disc_last();
        t_cmp_unaligned();
        t_long_stall();
        t_long_page();
        t_long_disc();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule